// File: doc/BRIEF.md
# Dual Word FIFO with Byte-Threshold Ready Flags

This block holds the data words that pass between a host-side register interface and a serial shifter. It has two FIFOs. The transmit FIFO takes 32-bit words from the host and hands them to the shifter. The receive FIFO takes words from the shifter and hands them to the host. Each direction stores two words.

For flag purposes, fill level is counted in bytes: each word counts as four bytes, so each FIFO holds eight bytes. This lets a 3-bit threshold per direction set when the direction reports "ready":
- The receive side is ready once its stored bytes exceed its threshold.
- The transmit side is ready once its free bytes exceed its threshold.

With four-byte words the usual settings are 3 for the receive threshold and 3 for the transmit threshold (bytes-per-word minus one, and seven minus bytes-per-word).

Each direction also reports empty and full. It keeps sticky error flags for a push into a full FIFO (overflow) and a pop from an empty one (underflow).

A one-cycle flush request raises a busy indication that clears itself once both FIFOs are empty. The flush also clears the sticky errors. A soft reset input does the same work in a single cycle. A FIFO-mode enable gates all data movement through the FIFOs.

Top module: `spi_word_fifo_pair`

## Requirements
- R1: After `rst`, both FIFOs are empty and not full, all four error flags are 0, `flush_busy` is 0, `tx_ready` is 1 and `rx_ready` is 0.
- R2: Each FIFO returns words in the order they were pushed. The popped word appears on its data output at the clock edge that performs the pop and is held until the next successful pop.
- R3: Each FIFO holds exactly DEPTH words (2 by default). `*_full` is 1 when DEPTH words are stored, `*_empty` is 1 when none are stored, and the two are never 1 together.
- R4: A push into a full FIFO is dropped. It sets that direction's overflow flag, which stays 1 until a flush or soft reset.
- R5: A pop from an empty FIFO sets that direction's underflow flag (sticky like R4) and leaves that direction's data output unchanged.
- R6: `rx_ready` is 1 exactly when the stored words × 4 is greater than `rx_thr`. The flag is registered, so a threshold change shows one cycle later.
- R7: `tx_ready` is 1 exactly when the free words × 4 is greater than `tx_thr`. The flag is registered in the same way as R6.
- R8: A one-cycle `flush_req` raises `flush_busy` on the next edge. While `flush_busy` is 1, both FIFOs are emptied, all error flags are cleared, and pushes and pops are ignored. `flush_busy` falls by itself at most two cycles after it rose.
- R9: `soft_rst` empties both FIFOs, clears all error flags and ends any flush, all in one cycle.
- R10: While `fifo_mode` is 0, pushes and pops have no effect: fill levels, data outputs and error flags are all unchanged.
- R11: A push and a pop in the same cycle on a FIFO that is neither empty nor full both take effect. The fill level is unchanged and the oldest word comes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of both FIFOs, errors and flush |
| fifo_mode | input | 1 | 1 enables data movement through the FIFOs |
| flush_req | input | 1 | Flush request (one-cycle pulse) |
| flush_busy | output | 1 | 1 while a flush is in progress; clears itself |
| tx_thr | input | 3 | Transmit ready threshold in bytes |
| rx_thr | input | 3 | Receive ready threshold in bytes |
| host_wr_en | input | 1 | Push `host_wr_data` into the transmit FIFO |
| host_wr_data | input | 32 | Word from the host |
| shf_tx_pop | input | 1 | Shifter takes a word from the transmit FIFO |
| shf_tx_data | output | 32 | Last word popped from the transmit FIFO |
| shf_rx_push | input | 1 | Push `shf_rx_data` into the receive FIFO |
| shf_rx_data | input | 32 | Word from the shifter |
| host_rd_en | input | 1 | Host takes a word from the receive FIFO |
| host_rd_data | output | 32 | Last word popped from the receive FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_ready | output | 1 | Transmit free bytes exceed `tx_thr` |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_ready | output | 1 | Receive stored bytes exceed `rx_thr` |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The FIFOs are exercised in several ways, and each one isolates a different fault:
- Filling each FIFO to two words and draining it in order shows whether ordering and the full/empty boundaries are right.
- Thresholds set away from their usual values (4 on receive, 6 on transmit) separate the stored-byte comparison from the free-byte comparison. They also show whether the comparison is strict.
- Pushing into a full FIFO and popping from an empty one show that dropped accesses corrupt no data and that the errors stay set.
- Flushes, soft resets, mode-off accesses and a simultaneous push-and-pop show which path clears state and which leaves it alone.

// File: rtl/spi_wfifo_pkg.sv
package spi_wfifo_pkg;
  localparam int WORD_W         = 32;
  localparam int DEPTH_WORDS    = 2;
  localparam int BYTES_PER_WORD = 4;
  localparam int THR_BITS       = 3;
endpackage

// File: rtl/spi_wfifo_core.sv
// One word FIFO with byte-counted ready flag and sticky access errors.
module spi_wfifo_core #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  parameter int BPW   = 4,
  parameter int THR_W = 3,
  parameter bit READY_ON_FREE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  input  logic [THR_W-1:0] thr,
  output logic             empty,
  output logic             full,
  output logic             ready,
  output logic             ovf,
  output logic             udf
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int CAP = DEPTH * BPW;
  localparam int BW0 = $clog2(CAP + 1);
  localparam int BW  = (BW0 > THR_W) ? BW0 + 1 : THR_W + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q, count_nxt;
  logic          do_push, do_pop;
  logic [BW-1:0] bytes_nxt, room_nxt, thr_ext;
  logic          ready_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = en & push & ~full & ~clr;
  assign do_pop  = en & pop & ~empty & ~clr;

  always_comb begin
    count_nxt = count_q;
    if (clr) count_nxt = '0;
    else begin
      case ({do_push, do_pop})
        2'b10:   count_nxt = count_q + CW'(1);
        2'b01:   count_nxt = count_q - CW'(1);
        default: count_nxt = count_q;
      endcase
    end
  end

  assign bytes_nxt = BW'(count_nxt) * BW'(BPW);
  assign room_nxt  = BW'(CAP) - bytes_nxt;
  assign thr_ext   = BW'(thr);

  generate
    if (READY_ON_FREE) begin : g_free
      assign ready_nxt = room_nxt > thr_ext;
    end else begin : g_fill
      assign ready_nxt = bytes_nxt > thr_ext;
    end
  endgenerate

  // storage: write port, no reset, so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
      ready   <= READY_ON_FREE ? (BW'(CAP) > thr_ext) : 1'b0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
    end else begin
      wr_ptr  <= clr ? '0 : (do_push ? bump(wr_ptr) : wr_ptr);
      rd_ptr  <= clr ? '0 : (do_pop ? bump(rd_ptr) : rd_ptr);
      count_q <= count_nxt;
      empty   <= (count_nxt == '0);
      full    <= (count_nxt == CW'(DEPTH));
      ready   <= ready_nxt;
      ovf     <= clr ? 1'b0 : (ovf | (en & push & full));
      udf     <= clr ? 1'b0 : (udf | (en & pop & empty));
    end
  end
endmodule

// File: rtl/spi_wfifo_flush.sv
// Self-clearing flush sequencer shared by both directions.
module spi_wfifo_flush (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic req,
  input  logic all_empty,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) busy <= 1'b0;
    else if (req)        busy <= 1'b1;
    else if (all_empty)  busy <= 1'b0;
  end
endmodule

// File: rtl/spi_word_fifo_pair.sv
module spi_word_fifo_pair
  import spi_wfifo_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int DEPTH = DEPTH_WORDS,
  parameter int BPW   = BYTES_PER_WORD,
  parameter int THR_W = THR_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             fifo_mode,
  input  logic             flush_req,
  output logic             flush_busy,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             host_wr_en,
  input  logic [DW-1:0]    host_wr_data,
  input  logic             shf_tx_pop,
  output logic [DW-1:0]    shf_tx_data,
  input  logic             shf_rx_push,
  input  logic [DW-1:0]    shf_rx_data,
  input  logic             host_rd_en,
  output logic [DW-1:0]    host_rd_data,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             tx_ready,
  output logic             tx_ovf,
  output logic             tx_udf,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             rx_ready,
  output logic             rx_ovf,
  output logic             rx_udf
);
  logic clr;
  assign clr = soft_rst | flush_busy;

  spi_wfifo_flush u_flush (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .req(flush_req),
    .all_empty(tx_empty & rx_empty), .busy(flush_busy)
  );

  spi_wfifo_core #(.DW(DW), .DEPTH(DEPTH), .BPW(BPW), .THR_W(THR_W),
                   .READY_ON_FREE(1'b1)) u_tx (
    .clk(clk), .rst(rst), .clr(clr), .en(fifo_mode),
    .push(host_wr_en), .din(host_wr_data),
    .pop(shf_tx_pop), .dout(shf_tx_data), .thr(tx_thr),
    .empty(tx_empty), .full(tx_full), .ready(tx_ready),
    .ovf(tx_ovf), .udf(tx_udf)
  );

  spi_wfifo_core #(.DW(DW), .DEPTH(DEPTH), .BPW(BPW), .THR_W(THR_W),
                   .READY_ON_FREE(1'b0)) u_rx (
    .clk(clk), .rst(rst), .clr(clr), .en(fifo_mode),
    .push(shf_rx_push), .din(shf_rx_data),
    .pop(host_rd_en), .dout(host_rd_data), .thr(rx_thr),
    .empty(rx_empty), .full(rx_full), .ready(rx_ready),
    .ovf(rx_ovf), .udf(rx_udf)
  );
endmodule

// File: rtl/spi_word_fifo_pair_chk.sv
module spi_word_fifo_pair_chk (
  input logic clk,
  input logic rst,
  input logic soft_rst,
  input logic fifo_mode,
  input logic flush_req,
  input logic flush_busy,
  input logic host_wr_en,
  input logic host_rd_en,
  input logic tx_empty,
  input logic tx_full,
  input logic tx_ovf,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_udf
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_empty && rx_empty && !flush_busy));
  // R3
  tx_not_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));
  // R3
  rx_not_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf && !soft_rst && !flush_busy) |=> tx_ovf);
  // R4
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ovf) |-> $past(host_wr_en && tx_full && fifo_mode));
  // R5
  udf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_udf) |-> $past(host_rd_en && rx_empty && fifo_mode));
  // R8
  flush_done_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_busy && tx_empty && rx_empty && !flush_req) |=> !flush_busy);
  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (tx_empty && rx_empty && !flush_busy && !tx_ovf && !rx_udf));
  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && !flush_busy && !soft_rst) |=> ($stable(tx_empty) && $stable(rx_empty)));
endmodule

bind spi_word_fifo_pair spi_word_fifo_pair_chk chk_i (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .fifo_mode(fifo_mode),
  .flush_req(flush_req), .flush_busy(flush_busy),
  .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
  .tx_empty(tx_empty), .tx_full(tx_full), .tx_ovf(tx_ovf),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_udf(rx_udf)
);

// File: tb/spi_word_fifo_pair_tb_top.sv
module spi_word_fifo_pair_tb_top;
  logic clk = 1'b0;
  logic rst, soft_rst, fifo_mode, flush_req, flush_busy;
  logic [2:0] tx_thr, rx_thr;
  logic host_wr_en, shf_tx_pop, shf_rx_push, host_rd_en;
  logic [31:0] host_wr_data, shf_tx_data, shf_rx_data, host_rd_data;
  logic tx_empty, tx_full, tx_ready, tx_ovf, tx_udf;
  logic rx_empty, rx_full, rx_ready, rx_ovf, rx_udf;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_word_fifo_pair dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .fifo_mode(fifo_mode),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .shf_tx_pop(shf_tx_pop), .shf_tx_data(shf_tx_data),
    .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_ready(tx_ready),
    .tx_ovf(tx_ovf), .tx_udf(tx_udf),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_ready(rx_ready),
    .rx_ovf(rx_ovf), .rx_udf(rx_udf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_push(input logic [31:0] d);
    host_wr_en = 1'b1; host_wr_data = d; cyc(); host_wr_en = 1'b0;
  endtask
  task automatic tx_pop();
    shf_tx_pop = 1'b1; cyc(); shf_tx_pop = 1'b0;
  endtask
  task automatic rx_push(input logic [31:0] d);
    shf_rx_push = 1'b1; shf_rx_data = d; cyc(); shf_rx_push = 1'b0;
  endtask
  task automatic rx_pop();
    host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
  endtask

  task automatic do_flush();
    flush_req = 1'b1; cyc(); flush_req = 1'b0;
    for (int i = 0; i < 4 && flush_busy; i++) cyc();
  endtask

  task automatic t_reset();
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);   chk("R1 flush_busy", flush_busy, 0);
    chk("R1 tx_ready", tx_ready, 1); chk("R1 rx_ready", rx_ready, 0);
    chk("R1 errors", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
  endtask

  task automatic t_tx_order();
    tx_push(32'hA0A0_0001);
    chk("R7 tx_ready one word thr3", tx_ready, 1);
    tx_push(32'hA0A0_0002);
    chk("R3 tx_full", tx_full, 1);
    chk("R7 tx_ready full thr3", tx_ready, 0);
    tx_pop(); chk("R2 tx first", shf_tx_data, 32'hA0A0_0001);
    tx_pop(); chk("R2 tx second", shf_tx_data, 32'hA0A0_0002);
    chk("R3 tx_empty", tx_empty, 1);
  endtask

  task automatic t_rx_order();
    rx_push(32'hB0B0_0001);
    chk("R6 rx_ready one word thr3", rx_ready, 1);
    rx_push(32'hB0B0_0002);
    chk("R3 rx_full", rx_full, 1);
    rx_pop(); chk("R2 rx first", host_rd_data, 32'hB0B0_0001);
    rx_pop(); chk("R2 rx second", host_rd_data, 32'hB0B0_0002);
    chk("R3 rx_empty", rx_empty, 1);
    chk("R6 rx_ready empty", rx_ready, 0);
  endtask

  task automatic t_thresholds();
    rx_thr = 3'd4; tx_thr = 3'd6; cyc();
    chk("R7 tx_ready empty thr6", tx_ready, 1);
    rx_push(32'h1); chk("R6 rx_ready 4 bytes thr4", rx_ready, 0);
    rx_push(32'h2); chk("R6 rx_ready 8 bytes thr4", rx_ready, 1);
    tx_push(32'h3); chk("R7 tx_ready 4 free thr6", tx_ready, 0);
    rx_thr = 3'd3; tx_thr = 3'd3; cyc();
    chk("R7 tx_ready 4 free thr3", tx_ready, 1);
    do_flush();
  endtask

  task automatic t_overflow();
    tx_push(32'hC1); tx_push(32'hC2); tx_push(32'hC3);
    chk("R4 tx_ovf set", tx_ovf, 1);
    chk("R4 tx_full kept", tx_full, 1);
    tx_pop(); chk("R4 data kept 1", shf_tx_data, 32'hC1);
    tx_pop(); chk("R4 data kept 2", shf_tx_data, 32'hC2);
    chk("R4 dropped word absent", tx_empty, 1);
    chk("R4 tx_ovf sticky", tx_ovf, 1);
    do_flush();
  endtask

  task automatic t_underflow();
    rx_push(32'hD1); rx_pop();
    chk("R5 rx word", host_rd_data, 32'hD1);
    rx_pop();
    chk("R5 rx_udf set", rx_udf, 1);
    chk("R5 rx data unchanged", host_rd_data, 32'hD1);
    tx_pop();
    chk("R5 tx_udf set", tx_udf, 1);
    cyc(); chk("R5 rx_udf sticky", rx_udf, 1);
  endtask

  task automatic t_flush();
    tx_push(32'hE1); rx_push(32'hE2); tx_push(32'hE3); tx_push(32'hE4);
    flush_req = 1'b1; cyc(); flush_req = 1'b0;
    chk("R8 busy raised", flush_busy, 1);
    host_wr_en = 1'b1; host_wr_data = 32'hEE; shf_rx_push = 1'b1; shf_rx_data = 32'hEF;
    cyc();
    host_wr_en = 1'b0; shf_rx_push = 1'b0;
    cyc();
    chk("R8 busy cleared within 2", flush_busy, 0);
    chk("R8 tx emptied", tx_empty, 1);
    chk("R8 rx emptied", rx_empty, 1);
    chk("R8 errors cleared", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
  endtask

  task automatic t_soft_rst();
    tx_push(32'hF1); tx_push(32'hF2); tx_push(32'hF3); rx_pop();
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
    chk("R9 tx_empty", tx_empty, 1);
    chk("R9 errors cleared", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
    tx_push(32'hF4); tx_pop();
    chk("R9 fresh order", shf_tx_data, 32'hF4);
  endtask

  task automatic t_mode_off();
    fifo_mode = 1'b0;
    tx_push(32'h99); rx_push(32'h98);
    chk("R10 tx still empty", tx_empty, 1);
    chk("R10 rx still empty", rx_empty, 1);
    tx_pop(); rx_pop();
    chk("R10 tx data unchanged", shf_tx_data, 32'hF4);
    chk("R10 no errors", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
    fifo_mode = 1'b1;
  endtask

  task automatic t_simul();
    tx_push(32'h51);
    host_wr_en = 1'b1; host_wr_data = 32'h52; shf_tx_pop = 1'b1; cyc();
    host_wr_en = 1'b0; shf_tx_pop = 1'b0;
    chk("R11 oldest out", shf_tx_data, 32'h51);
    chk("R11 level kept", {tx_empty, tx_full}, 2'b00);
    tx_pop(); chk("R11 new word", shf_tx_data, 32'h52);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; fifo_mode = 1'b1; flush_req = 1'b0;
    tx_thr = 3'd3; rx_thr = 3'd3;
    host_wr_en = 1'b0; shf_tx_pop = 1'b0; shf_rx_push = 1'b0; host_rd_en = 1'b0;
    host_wr_data = '0; shf_rx_data = '0;
    @(negedge clk); cyc(); cyc(); cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_tx_order();
    t_rx_order();
    t_thresholds();
    t_overflow();
    t_underflow();
    t_flush();
    t_soft_rst();
    t_mode_off();
    t_simul();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule